// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel that watches a free-running time counter held outside it. Software loads a compare value and selects a mode. Each time the counter reports a new value equal to the active compare value, the channel raises an event flag. It can also flip its output pin, or pulse it for one clock, and it can hold an interrupt request. Further channels come from further instances.

The compare value has two stages. While the channel is disabled, a compare write loads the active value directly. While the channel is enabled, the active value is armed and awaiting a match, so a compare write goes into a holding stage. That held value takes over as the active value when the armed match fires. A pulse-per-second output therefore needs only one compare write per event. On each event, software queues the instant after next, advancing the value by one billion counts modulo the 31-bit counter range, and clears the flag.

Top module: `tmr_cmp_channel`

## Requirements
- R1: After reset, `csr_o`, `cmp_o`, `pin_o` and `irq_o` are all zero.
- R2: `csr_o` reads the event flag at bit 7, the interrupt enable at bit 6 and the 4-bit mode at bits 5:2. Bits 1:0 always read 0, and whatever a control write puts in them is ignored. A control write loads the enable and the mode from bits 6 and 5:2.
- R3: The event flag clears when a control write has bit 7 at 1. A control write with bit 7 at 0 leaves the flag as it is. If a clearing write and a match fall in the same cycle, the flag stays set.
- R4: A match occurs in a cycle where four conditions hold: the mode is nonzero, `arm_i` is high, `cnt_upd_i` is high, and `cnt_i` equals the active compare value. A match sets the flag, which is visible on `csr_o` in the following cycle.
- R5: `irq_o` is high exactly while both the flag and the interrupt enable are set.
- R6: In mode 5, every match inverts `pin_o` from the following cycle onward.
- R7: In mode 15, `pin_o` is high for exactly the one cycle after a match and low otherwise.
- R8: In mode 0, no match occurs and `pin_o` is driven low from the next cycle.
- R9: A compare write while the mode is 0 sets the active value, shown on `cmp_o` in the next cycle, and discards any held value.
- R10: A compare write while the mode is nonzero leaves `cmp_o` unchanged and replaces the held value, so the last such write wins. On the next match, the held value becomes the active value.
- R11: A match with no held value keeps the active compare value unchanged.
- R12: Advancing the compare value by 1,000,000,000 modulo 2^31 with one write per event produces one output pulse per step, including across counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current time-counter value |
| cnt_upd_i | input | 1 | Counter has taken a new value this cycle |
| arm_i | input | 1 | Timer-level permission for compare events |
| csr_we_i | input | 1 | Control/status write strobe |
| csr_wdata_i | input | 8 | Control/status write data |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write data |
| csr_o | output | 8 | Control/status readback |
| cmp_o | output | CNT_W | Active compare value |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request level |

## Verification
The assertions assume that `rst_ni` is low at time zero. They also assume that the mode only moves between 0, 5 and 15. The pulse and toggle properties look at the mode one cycle back so that a mode change at the same edge does not upset them. The stimulus starts in reset, and it reaches modes 5 and 15 only by way of explicit writes. Every input is changed at the falling edge, so each match, clear and compare write lands on a single, well-defined rising edge.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CSR_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int MODE_LSB = 2;
  localparam int MODE_W   = 4;
  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_OFF    = 4'd0;
  localparam mode_t MODE_TOGGLE = 4'd5;
  localparam mode_t MODE_PULSE  = 4'd15;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [FLAG_BIT:MODE_LSB] wdata_i,
  input  logic                   hit_i,
  output logic                   flag_o,
  output logic                   ie_o,
  output mode_t                  mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      ie_o   <= 1'b0;
      mode_o <= MODE_OFF;
    end else begin
      if (we_i) begin
        ie_o   <= wdata_i[IE_BIT];
        mode_o <= wdata_i[MODE_MSB:MODE_LSB];
      end
      // a match wins over a simultaneous clear so no event is lost
      if (hit_i)                         flag_o <= 1'b1;
      else if (we_i && wdata_i[FLAG_BIT]) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tcc_cmp_buf.sv
module tcc_cmp_buf #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         armed_i,
  input  logic         hit_i,
  output logic [W-1:0] active_o,
  output logic         pend_v_o,
  output logic [W-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      pend_o   <= '0;
      pend_v_o <= 1'b0;
    end else if (we_i && !armed_i) begin
      active_o <= wdata_i;
      pend_v_o <= 1'b0;
    end else begin
      if (hit_i && pend_v_o) active_o <= pend_o;
      if (we_i) begin
        pend_o   <= wdata_i;
        pend_v_o <= 1'b1;
      end else if (hit_i) begin
        pend_v_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcc_pin.sv
module tcc_pin
  import tcc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  hit_i,
  output logic  pin_o
);
  logic pin_d;

  always_comb begin
    unique case (mode_i)
      MODE_OFF:    pin_d = 1'b0;
      MODE_TOGGLE: pin_d = hit_i ? ~pin_o : pin_o;
      MODE_PULSE:  pin_d = hit_i;
      default:     pin_d = pin_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else         pin_o <= pin_d;
  end
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_upd_i,
  input  logic             arm_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CSR_W-1:0] csr_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pin_o,
  output logic             irq_o
);
  logic             flag_q, ie_q, armed, hit, pend_v;
  logic [CNT_W-1:0] active_q, pend_q;
  mode_t            mode_q;
  logic             unused_wbits;

  assign unused_wbits = |csr_wdata_i[MODE_LSB-1:0];

  assign armed = (mode_q != MODE_OFF);
  assign hit   = armed && arm_i && cnt_upd_i && (cnt_i == active_q);

  tcc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i[FLAG_BIT:MODE_LSB]),
    .hit_i   (hit),
    .flag_o  (flag_q),
    .ie_o    (ie_q),
    .mode_o  (mode_q)
  );

  tcc_cmp_buf #(.W(CNT_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cmp_we_i),
    .wdata_i  (cmp_wdata_i),
    .armed_i  (armed),
    .hit_i    (hit),
    .active_o (active_q),
    .pend_v_o (pend_v),
    .pend_o   (pend_q)
  );

  tcc_pin u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .hit_i  (hit),
    .pin_o  (pin_o)
  );

  assign csr_o = {flag_q, ie_q, mode_q, {MODE_LSB{1'b0}}};
  assign cmp_o = active_q;
  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/tmr_cmp_channel_chk.sv
module tmr_cmp_channel_chk #(
  parameter int CNT_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hit,
  input logic             pend_v,
  input logic [CNT_W-1:0] pend_q,
  input logic             csr_we_i,
  input logic [7:0]       csr_wdata_i,
  input logic             cmp_we_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic [7:0]       csr_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic             pin_o,
  input logic             irq_o
);
  a_r3_clear_wins_without_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[7] && !hit) |=> !csr_o[7]);

  a_r4_hit_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> csr_o[7]);

  a_r5_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (csr_o[7] && csr_o[6]));

  a_r6_toggle_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit) && $past(csr_o[5:2]) == 4'd5) |-> (pin_o != $past(pin_o)));

  a_r7_pulse_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o && csr_o[5:2] == 4'd15 && $past(csr_o[5:2]) == 4'd15) |-> $past(hit));

  a_r8_off_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(csr_o[5:2]) == 4'd0) |-> !pin_o);

  a_r9_direct_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && csr_o[5:2] == 4'd0) |=> (cmp_o == $past(cmp_wdata_i)));

  a_r10_promote_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && pend_v) |=> (cmp_o == $past(pend_q)));
endmodule

bind tmr_cmp_channel tmr_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hit         (hit),
  .pend_v      (pend_v),
  .pend_q      (pend_q),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .cmp_we_i    (cmp_we_i),
  .cmp_wdata_i (cmp_wdata_i),
  .csr_o       (csr_o),
  .cmp_o       (cmp_o),
  .pin_o       (pin_o),
  .irq_o       (irq_o)
);

// File: tb/tmr_cmp_channel_bench.sv
module tmr_cmp_channel_bench;
  localparam int CNT_W = 31;
  localparam longint PERIOD = 64'd1000000000;
  localparam longint MODV   = 64'd1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             upd = 1'b0;
  logic             arm = 1'b1;
  logic             csr_we = 1'b0;
  logic [7:0]       csr_wd = '0;
  logic             cmp_we = 1'b0;
  logic [CNT_W-1:0] cmp_wd = '0;
  logic [7:0]       csr;
  logic [CNT_W-1:0] cmp;
  logic             pin, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_cmp_channel #(.CNT_W(CNT_W)) u_tmr_cmp_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_upd_i(upd), .arm_i(arm),
    .csr_we_i(csr_we), .csr_wdata_i(csr_wd), .cmp_we_i(cmp_we),
    .cmp_wdata_i(cmp_wd), .csr_o(csr), .cmp_o(cmp), .pin_o(pin), .irq_o(irq)
  );

  // {kind[2], wdata[32], cnt[31], upd, exp_pin, exp_irq, exp_csr[8]}
  // kind: 0 = counter tick, 1 = control write, 2 = compare write
  localparam int NV = 15;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 32'h80,  31'd0,   1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 32'd100, 31'd0,   1'b0, 1'b0, 1'b0, 8'h00},
    {2'd1, 32'h54,  31'd0,   1'b0, 1'b0, 1'b0, 8'h54},
    {2'd2, 32'd200, 31'd0,   1'b0, 1'b0, 1'b0, 8'h54},
    {2'd0, 32'd0,   31'd99,  1'b1, 1'b0, 1'b0, 8'h54},
    {2'd0, 32'd0,   31'd100, 1'b1, 1'b1, 1'b1, 8'hD4},
    {2'd1, 32'hD4,  31'd0,   1'b0, 1'b1, 1'b0, 8'h54},
    {2'd0, 32'd0,   31'd100, 1'b1, 1'b1, 1'b0, 8'h54},
    {2'd0, 32'd0,   31'd200, 1'b0, 1'b1, 1'b0, 8'h54},
    {2'd0, 32'd0,   31'd200, 1'b1, 1'b0, 1'b1, 8'hD4},
    {2'd1, 32'h3D,  31'd0,   1'b0, 1'b0, 1'b0, 8'hBC},
    {2'd0, 32'd0,   31'd200, 1'b1, 1'b1, 1'b0, 8'hBC},
    {2'd0, 32'd0,   31'd201, 1'b1, 1'b0, 1'b0, 8'hBC},
    {2'd1, 32'h00,  31'd0,   1'b0, 1'b0, 1'b0, 8'h80},
    {2'd0, 32'd0,   31'd200, 1'b1, 1'b0, 1'b0, 8'h80}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, clock once, release strobes, sample at the next falling edge
  task automatic cyc(input logic cw, input logic mw, input logic [31:0] wd,
                     input logic [CNT_W-1:0] cv, input logic up);
    csr_we = cw; cmp_we = mw; csr_wd = wd[7:0]; cmp_wd = wd[CNT_W-1:0];
    cnt = cv; upd = up;
    @(posedge clk);
    #2;
    csr_we = 1'b0; cmp_we = 1'b0; upd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint act_v, nxt_v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 csr", {24'd0, csr}, 32'h00);
    check("R1 cmp", {1'b0, cmp}, 32'd0);
    check("R1 pin", {31'd0, pin}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 (bit0 ignored at step 11), R4, R5, R6, R7, R8, R9, R10, R11
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][75:74] == 2'd1, VEC[i][75:74] == 2'd2, VEC[i][73:42],
          VEC[i][41:11], VEC[i][10]);
      check($sformatf("R2/R4-R8 vec%0d csr", i), {24'd0, csr}, {24'd0, VEC[i][7:0]});
      check($sformatf("R6/R7/R8 vec%0d pin", i), {31'd0, pin}, {31'd0, VEC[i][9]});
      check($sformatf("R5 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][8]});
    end
    check("R11 active kept", {1'b0, cmp}, 32'd200);

    // R4: arm_i low blocks a match
    cyc(1, 0, 32'hD4, 0, 0);
    check("R3 clear", {24'd0, csr}, 32'h54);
    arm = 1'b0;
    cyc(0, 0, 0, 31'd200, 1);
    check("R4 arm low csr", {24'd0, csr}, 32'h54);
    check("R4 arm low pin", {31'd0, pin}, 32'd0);
    arm = 1'b1;
    cyc(0, 0, 0, 31'd200, 1);
    check("R4 arm high csr", {24'd0, csr}, 32'hD4);
    check("R6 toggle up", {31'd0, pin}, 32'd1);

    // R3: clear and match in the same cycle keeps the flag
    cyc(1, 0, 32'hD4, 31'd200, 1);
    check("R3 set wins", {24'd0, csr}, 32'hD4);
    check("R6 toggle down", {31'd0, pin}, 32'd0);

    // R10: held value, last write wins, promoted on match
    cyc(1, 0, 32'hD4, 0, 0);
    cyc(0, 1, 32'd300, 0, 0);
    cyc(0, 1, 32'd400, 0, 0);
    check("R10 active unchanged", {1'b0, cmp}, 32'd200);
    cyc(0, 0, 0, 31'd200, 1);
    check("R10 promoted", {1'b0, cmp}, 32'd400);
    cyc(1, 0, 32'hD4, 0, 0);
    cyc(0, 0, 0, 31'd300, 1);
    check("R10 overwritten value no match", {24'd0, csr}, 32'h54);
    cyc(0, 0, 0, 31'd400, 1);
    check("R10 match on last write", {24'd0, csr}, 32'hD4);
    check("R11 no held value", {1'b0, cmp}, 32'd400);

    // R9: write while disabled loads directly and drops held value
    cyc(1, 0, 32'hD4, 0, 0);
    cyc(0, 1, 32'd500, 0, 0);
    cyc(1, 0, 32'h00, 0, 0);
    check("R8 off pin low", {31'd0, pin}, 32'd0);
    cyc(0, 1, 32'd600, 0, 0);
    check("R9 direct load", {1'b0, cmp}, 32'd600);
    cyc(1, 0, 32'h54, 0, 0);
    cyc(0, 0, 0, 31'd600, 1);
    check("R9 match", {24'd0, csr}, 32'hD4);
    check("R9 held value discarded", {1'b0, cmp}, 32'd600);

    // R12: pulse-per-second stepping with wrap
    cyc(1, 0, 32'h80, 0, 0);
    act_v = 64'd16;
    nxt_v = (act_v + PERIOD) % MODV;
    cyc(0, 1, act_v[31:0], 0, 0);
    cyc(1, 0, 32'h3C, 0, 0);
    cyc(0, 1, nxt_v[31:0], 0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, act_v[CNT_W-1:0], 1);
      check($sformatf("R12 pulse %0d", k), {31'd0, pin}, 32'd1);
      check($sformatf("R12 flag %0d", k), {24'd0, csr}, 32'hBC);
      check($sformatf("R12 next %0d", k), {1'b0, cmp}, nxt_v[31:0]);
      act_v = nxt_v;
      nxt_v = (act_v + PERIOD) % MODV;
      cyc(0, 1, nxt_v[31:0], 0, 0);
      cyc(1, 0, 32'hBC, 0, 0);
      check($sformatf("R7 pulse end %0d", k), {31'd0, pin}, 32'd0);
    end
    finish_run();
  end
endmodule